// File: doc/BRIEF.md
# Host-to-Expansion Cycle Bridge Controller

This block sits beside the host processor bus and watches every cycle the host begins. When a cycle is not claimed by a memory or I/O device on the host side, the block asks one of two expansion-bus cycle engines to carry it out. A separate input picks the engine, wide-bus or narrow-bus. When the engine reports completion, the block returns ready to the host. The engines, the data buffers and the address decoders are outside the block. It only sequences starts, completions and ready.

Single memory writes can be posted. The block strobes the data buffer latch and releases the host with ready at once. The expansion write then drains in the background. At most one posted write is outstanding at a time. A later host cycle that needs the expansion bus waits until the drain ends and gets ready only when its own expansion cycle completes.

The block also relays bus-hold requests from the central arbiter to the host processor. It will not interrupt a locked sequence. It also samples two configuration straps on each rising edge of the power-good input.

Top module: `xbus_bridge_ctrl`

## Requirements
- R1: A host cycle begins at a clock edge where any bit of `host_strb_n` is low (the strobes are active-low and combined so that any single low counts) while the block is idle.
- R2: When `loc_mem_n` or `loc_io_n` is low at the beginning of a cycle, no `xs_start`, no latch strobe and no ready is produced for it.
- R3: A forwarded cycle raises `xs_start` for exactly one clock, in the clock after the beginning edge. During that clock, `xs_isa` equals `tgt_isa` and `xs_write` equals `host_wr`, both as captured at the beginning edge.
- R4: For a non-posted cycle, `host_erdy_n` goes low for one clock in the clock after `xs_done` is sampled high. `host_rdy_n` then goes low for one clock in the clock that follows.
- R5: A cycle is posted when `host_mio`=1 (memory), `host_wr`=1 (write), `host_dc`=1 (data) and `post_en_n`=0. In the clock after the beginning edge, `xs_start`, `xs_post_latch` and early ready are all active, and `host_rdy_n` is low one clock later. I/O cycles and reads are never posted.
- R6: While a posted write is draining, a new forwarded cycle gets no `xs_start` until `xs_done` ends the drain. Its `xs_start` comes in the clock after that completion, and its ready follows its own completion as in R4. The completion that ends a drain produces no ready.
- R7: `xs_done` while idle with no drain outstanding is ignored: no ready is produced.
- R8: `host_hold` rises in the clock after `arb_hold_req`=1 is sampled with `host_lock_n`=1. While `host_lock_n`=0 it stays low. It falls in the clock after `arb_hold_req` is sampled low.
- R9: `arb_hlda` is high only in a clock after both `host_hold` and `host_hlda` were sampled high with `arb_hold_req` still high.
- R10: `mode_base` is loaded with (`strap_amode`=0 and `strap_nxt`=1) only on a rising edge of `pwr_good`, seen after a synchronizer. Strap changes at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_strb_n | input | NUM_STRB (2) | Active-low host address strobes |
| host_dc | input | 1 | Cycle type: 1 data, 0 control |
| host_wr | input | 1 | Cycle type: 1 write, 0 read |
| host_mio | input | 1 | Cycle type: 1 memory, 0 I/O |
| loc_mem_n | input | 1 | Active-low host-side memory decode |
| loc_io_n | input | 1 | Active-low host-side I/O decode |
| post_en_n | input | 1 | Active-low posted write enable |
| tgt_isa | input | 1 | Engine select: 1 narrow engine, 0 wide engine |
| host_lock_n | input | 1 | Active-low host lock |
| host_erdy_n | output | 1 | Active-low early ready to host |
| host_rdy_n | output | 1 | Active-low ready to host |
| xs_start | output | 1 | One-clock start to expansion engine |
| xs_isa | output | 1 | Engine select for the current cycle |
| xs_write | output | 1 | Direction of the current cycle |
| xs_mem | output | 1 | Memory/I/O of the current cycle |
| xs_post_latch | output | 1 | One-clock strobe to latch posted data |
| xs_done | input | 1 | Expansion cycle completion |
| arb_hold_req | input | 1 | Hold request from the arbiter |
| host_hold | output | 1 | Hold request to the host |
| host_hlda | input | 1 | Hold acknowledge from the host |
| arb_hlda | output | 1 | Hold acknowledge to the arbiter |
| strap_amode | input | 1 | Address-mode strap |
| strap_nxt | input | 1 | Mode pin sampled at power-good |
| pwr_good | input | 1 | Power-good, asynchronous |
| mode_base | output | 1 | Selected operating mode |

## Verification
On every cycle, the embedded properties check four things: the start pulse is one clock wide, ready trails early ready by one clock, hold never rises out of a locked state, and the acknowledge to the arbiter follows both a hold and the host's acknowledge. The same properties also check that the mode changes only on a power-good edge, and that a posted cycle produces start, latch and early ready together. Only the bench's scenarios can show the cycle-level ordering of a cycle that waits behind a drain. They also show that local decodes and stray completions yield no ready, and that engine select and direction are carried through. A reference model in the bench tracks the outstanding posted write through random mixes of these cases.

// File: rtl/xbb_pkg.sv
// Package: shared types for the host-to-expansion cycle bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package xbb_pkg;

    // Sequencer states for host cycles
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,   // no non-posted cycle in flight
        SEQ_WAIT = 2'd1,   // forwarded cycle awaiting completion
        SEQ_PEND = 2'd2    // new cycle parked behind a draining post
    } seq_state_t;

    // Attributes of a captured host cycle
    typedef struct packed {
        logic mem;
        logic wr;
        logic isa;
    } cyc_attr_t;

endpackage

// File: rtl/xbb_cfg_strap.sv
// Module: xbb_cfg_strap
// Samples the mode straps on each rising edge of power-good.
// Assumes: pwr_good is asynchronous and is synchronized here with
// SYNC_STAGES flops; the straps are static around the edge.
module xbb_cfg_strap #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic strap_amode,
    input  logic strap_nxt,
    output logic mode_base
);
    logic [SYNC_STAGES-1:0] pg_sync;
    logic                   pg_prev;
    logic                   pg_rise;

    // Synchronizer chain for power-good
    generate
        for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) pg_sync[0] <= 1'b0;
                    else        pg_sync[0] <= pwr_good;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) pg_sync[gi] <= 1'b0;
                    else        pg_sync[gi] <= pg_sync[gi-1];
                end
            end
        end
    endgenerate

    assign pg_rise = pg_sync[SYNC_STAGES-1] & ~pg_prev;

    // Edge detector and strap sampling register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_prev   <= 1'b0;
            mode_base <= 1'b0;
        end else begin
            pg_prev <= pg_sync[SYNC_STAGES-1];
            if (pg_rise) mode_base <= ~strap_amode & strap_nxt;
        end
    end

    AST_MODE_ON_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_base) |-> $past(pg_rise)); // R10

endmodule

// File: rtl/xbb_hold_relay.sv
// Module: xbb_hold_relay
// Passes the arbiter's hold request to the host and the host's
// acknowledge back to the arbiter, never breaking a locked sequence.
// Assumes: all inputs are synchronous to clk.
module xbb_hold_relay (
    input  logic clk,
    input  logic rst_n,
    input  logic arb_hold_req,
    input  logic host_lock_n,
    input  logic host_hlda,
    output logic host_hold,
    output logic arb_hlda
);
    // Hold request and acknowledge registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_hold <= 1'b0;
            arb_hlda  <= 1'b0;
        end else begin
            host_hold <= arb_hold_req & (host_hold | host_lock_n);
            arb_hlda  <= arb_hold_req & host_hold & host_hlda;
        end
    end

    AST_NO_HOLD_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_hold) |-> $past(host_lock_n)); // R8

    AST_HLDA_AFTER_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_hlda) |-> ($past(host_hold) && $past(host_hlda))); // R9

endmodule

// File: rtl/xbb_ready_gen.sv
// Module: xbb_ready_gen
// Turns the sequencer's early-ready pulse into the two active-low
// ready outputs, the normal one trailing the early one by a clock.
// Assumes: early_pulse is a registered one-clock pulse.
module xbb_ready_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic early_pulse,
    output logic host_erdy_n,
    output logic host_rdy_n
);
    assign host_erdy_n = ~early_pulse;

    // One-clock delay from early ready to ready
    always_ff @(posedge clk) begin
        if (!rst_n) host_rdy_n <= 1'b1;
        else        host_rdy_n <= ~early_pulse;
    end

    AST_RDY_TRAILS_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !host_erdy_n |=> !host_rdy_n); // R4

    AST_RDY_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdy_n |=> host_rdy_n); // R4

endmodule

// File: rtl/xbb_cycle_seq.sv
// Module: xbb_cycle_seq
// Decides for each host cycle whether to forward it, posts single
// memory writes, starts the expansion engine and raises early ready.
// Assumes: the host issues no new cycle before ready of the previous
// non-posted one; xs_done is a one-clock pulse per started cycle.
module xbb_cycle_seq
    import xbb_pkg::*;
#(
    parameter int NUM_STRB = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_STRB-1:0] host_strb_n,
    input  logic                host_dc,
    input  logic                host_wr,
    input  logic                host_mio,
    input  logic                loc_mem_n,
    input  logic                loc_io_n,
    input  logic                post_en_n,
    input  logic                tgt_isa,
    input  logic                xs_done,
    output logic                xs_start,
    output logic                xs_isa,
    output logic                xs_write,
    output logic                xs_mem,
    output logic                xs_post_latch,
    output logic                early_pulse
);
    seq_state_t state;
    cyc_attr_t  attr;
    logic       post_busy;
    logic       strb_hit;
    logic       is_local;
    logic       fwd_hit;
    logic       postable;

    // Cycle qualification from strobes, decodes and cycle type
    always_comb begin
        strb_hit = ~(&host_strb_n);
        is_local = ~loc_mem_n | ~loc_io_n;
        fwd_hit  = strb_hit & ~is_local;
        postable = host_mio & host_wr & host_dc & ~post_en_n;
    end

    // Sequencer: launch, post, park and complete host cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= SEQ_IDLE;
            attr          <= '0;
            post_busy     <= 1'b0;
            xs_start      <= 1'b0;
            xs_post_latch <= 1'b0;
            early_pulse   <= 1'b0;
        end else begin
            xs_start      <= 1'b0;
            xs_post_latch <= 1'b0;
            early_pulse   <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (post_busy && xs_done) post_busy <= 1'b0;
                    if (fwd_hit) begin
                        attr <= '{mem: host_mio, wr: host_wr, isa: tgt_isa};
                        if (post_busy && !xs_done) begin
                            state <= SEQ_PEND;
                        end else if (postable) begin
                            xs_start      <= 1'b1;
                            xs_post_latch <= 1'b1;
                            early_pulse   <= 1'b1;
                            post_busy     <= 1'b1;
                        end else begin
                            xs_start <= 1'b1;
                            state    <= SEQ_WAIT;
                        end
                    end
                end
                SEQ_PEND: begin
                    if (xs_done) begin
                        post_busy <= 1'b0;
                        xs_start  <= 1'b1;
                        state     <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (xs_done) begin
                        early_pulse <= 1'b1;
                        state       <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign xs_isa   = attr.isa;
    assign xs_write = attr.wr;
    assign xs_mem   = attr.mem;

    AST_START_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        xs_start |=> !xs_start); // R3

    AST_LOCAL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && strb_hit && is_local) |=> !xs_start); // R2

    AST_POST_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        xs_post_latch |-> (xs_start && early_pulse)); // R5

    AST_DRAIN_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_PEND) |-> !early_pulse); // R6

endmodule

// File: rtl/xbus_bridge_ctrl.sv
// Module: xbus_bridge_ctrl (top)
// Host-to-expansion cycle bridge controller: cycle sequencing, ready
// generation, hold relay and mode strap sampling.
// Assumes: single clock domain except pwr_good; synchronous reset.
module xbus_bridge_ctrl
    import xbb_pkg::*;
#(
    parameter int NUM_STRB    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_STRB-1:0] host_strb_n,
    input  logic                host_dc,
    input  logic                host_wr,
    input  logic                host_mio,
    input  logic                loc_mem_n,
    input  logic                loc_io_n,
    input  logic                post_en_n,
    input  logic                tgt_isa,
    input  logic                host_lock_n,
    output logic                host_erdy_n,
    output logic                host_rdy_n,
    output logic                xs_start,
    output logic                xs_isa,
    output logic                xs_write,
    output logic                xs_mem,
    output logic                xs_post_latch,
    input  logic                xs_done,
    input  logic                arb_hold_req,
    output logic                host_hold,
    input  logic                host_hlda,
    output logic                arb_hlda,
    input  logic                strap_amode,
    input  logic                strap_nxt,
    input  logic                pwr_good,
    output logic                mode_base
);
    logic early_pulse;

    xbb_cycle_seq #(.NUM_STRB(NUM_STRB)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_strb_n   (host_strb_n),
        .host_dc       (host_dc),
        .host_wr       (host_wr),
        .host_mio      (host_mio),
        .loc_mem_n     (loc_mem_n),
        .loc_io_n      (loc_io_n),
        .post_en_n     (post_en_n),
        .tgt_isa       (tgt_isa),
        .xs_done       (xs_done),
        .xs_start      (xs_start),
        .xs_isa        (xs_isa),
        .xs_write      (xs_write),
        .xs_mem        (xs_mem),
        .xs_post_latch (xs_post_latch),
        .early_pulse   (early_pulse)
    );

    xbb_ready_gen u_rdy (
        .clk         (clk),
        .rst_n       (rst_n),
        .early_pulse (early_pulse),
        .host_erdy_n (host_erdy_n),
        .host_rdy_n  (host_rdy_n)
    );

    xbb_hold_relay u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .arb_hold_req (arb_hold_req),
        .host_lock_n  (host_lock_n),
        .host_hlda    (host_hlda),
        .host_hold    (host_hold),
        .arb_hlda     (arb_hlda)
    );

    xbb_cfg_strap #(.SYNC_STAGES(SYNC_STAGES)) u_strap (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good    (pwr_good),
        .strap_amode (strap_amode),
        .strap_nxt   (strap_nxt),
        .mode_base   (mode_base)
    );

    AST_START_NEEDS_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (xs_start && !xs_post_latch) |-> host_erdy_n); // R3

endmodule

// File: tb/xbus_bridge_ctrl_tb.sv
module xbus_bridge_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] host_strb_n;
    logic       host_dc, host_wr, host_mio, loc_mem_n, loc_io_n, post_en_n, tgt_isa;
    logic       host_lock_n, host_erdy_n, host_rdy_n;
    logic       xs_start, xs_isa, xs_write, xs_mem, xs_post_latch, xs_done;
    logic       arb_hold_req, host_hold, host_hlda, arb_hlda;
    logic       strap_amode, strap_nxt, pwr_good, mode_base;

    int n_chk  = 0;
    int n_fail = 0;
    bit busy_m = 1'b0;   // model: posted write outstanding

    always #5 clk = ~clk;

    xbus_bridge_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_strb_n(host_strb_n), .host_dc(host_dc),
        .host_wr(host_wr), .host_mio(host_mio), .loc_mem_n(loc_mem_n),
        .loc_io_n(loc_io_n), .post_en_n(post_en_n), .tgt_isa(tgt_isa),
        .host_lock_n(host_lock_n), .host_erdy_n(host_erdy_n), .host_rdy_n(host_rdy_n),
        .xs_start(xs_start), .xs_isa(xs_isa), .xs_write(xs_write), .xs_mem(xs_mem),
        .xs_post_latch(xs_post_latch), .xs_done(xs_done), .arb_hold_req(arb_hold_req),
        .host_hold(host_hold), .host_hlda(host_hlda), .arb_hlda(arb_hlda),
        .strap_amode(strap_amode), .strap_nxt(strap_nxt), .pwr_good(pwr_good),
        .mode_base(mode_base)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    function automatic bit exp_fwd(input bit lm_n, input bit li_n);
        return lm_n & li_n;
    endfunction

    function automatic bit exp_post(input bit mio, input bit wr, input bit dc, input bit pe_n);
        return mio & wr & dc & ~pe_n;
    endfunction

    // Waits lat clocks, then completes a started non-posted cycle (R4)
    task automatic finish_cycle(input int lat);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            eq("R4 wait no early ready", host_erdy_n, 1);
        end
        xs_done = 1'b1;
        @(negedge clk);
        xs_done = 1'b0;
        eq("R4 early ready", host_erdy_n, 0);
        eq("R4 ready not yet", host_rdy_n, 1);
        @(negedge clk);
        eq("R4 ready", host_rdy_n, 0);
        eq("R4 early ready one clock", host_erdy_n, 1);
    endtask

    // One host cycle; called at a negedge
    task automatic host_cycle(input bit [1:0] strb, input bit mio, input bit wr, input bit dc,
                              input bit lm_n, input bit li_n, input bit pe_n,
                              input bit isa, input int lat);
        bit fwd  = exp_fwd(lm_n, li_n);
        bit post = exp_post(mio, wr, dc, pe_n);
        host_strb_n = strb; host_mio = mio; host_wr = wr; host_dc = dc;
        loc_mem_n = lm_n; loc_io_n = li_n; post_en_n = pe_n; tgt_isa = isa;
        @(negedge clk);
        host_strb_n = 2'b11;
        if (!fwd) begin
            eq("R2 local no start", xs_start, 0);
            eq("R2 local no latch", xs_post_latch, 0);
            eq("R2 local no early ready", host_erdy_n, 1);
            @(negedge clk);
            eq("R2 local no ready", host_rdy_n, 1);
            return;
        end
        if (busy_m) begin
            eq("R6 start withheld during drain", xs_start, 0);
            @(negedge clk);
            eq("R6 still withheld", xs_start, 0);
            xs_done = 1'b1;
            @(negedge clk);
            xs_done = 1'b0;
            busy_m = 1'b0;
            eq("R6 start after drain", xs_start, 1);
            eq("R6 no ready for drain", host_erdy_n, 1);
            eq("R3 isa after drain", xs_isa, isa);
            finish_cycle(lat);
            return;
        end
        eq("R1 R3 start", xs_start, 1);
        eq("R3 isa select", xs_isa, isa);
        eq("R3 write dir", xs_write, wr);
        if (post) begin
            eq("R5 latch strobe", xs_post_latch, 1);
            eq("R5 early ready at once", host_erdy_n, 0);
            @(negedge clk);
            eq("R5 ready", host_rdy_n, 0);
            eq("R3 start one clock", xs_start, 0);
            busy_m = 1'b1;
        end else begin
            eq("R5 not posted no latch", xs_post_latch, 0);
            eq("R5 not posted no early ready", host_erdy_n, 1);
            finish_cycle(lat);
        end
    endtask

    // Stray or draining completion (R6, R7)
    task automatic lone_done();
        bit was_busy = busy_m;
        xs_done = 1'b1;
        @(negedge clk);
        xs_done = 1'b0;
        busy_m = 1'b0;
        eq(was_busy ? "R6 drain gives no early ready" : "R7 stray done ignored", host_erdy_n, 1);
        @(negedge clk);
        eq(was_busy ? "R6 drain gives no ready" : "R7 stray done no ready", host_rdy_n, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h1234_5a5a));
        rst_n = 1'b0; host_strb_n = 2'b11; host_dc = 0; host_wr = 0; host_mio = 0;
        loc_mem_n = 1; loc_io_n = 1; post_en_n = 1; tgt_isa = 0; host_lock_n = 1;
        xs_done = 0; arb_hold_req = 0; host_hlda = 0;
        strap_amode = 1; strap_nxt = 0; pwr_good = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        eq("R4 reset ready high", host_rdy_n, 1);
        eq("R4 reset early high", host_erdy_n, 1);
        eq("R3 reset no start", xs_start, 0);
        eq("R8 reset no hold", host_hold, 0);
        eq("R10 reset mode", mode_base, 0);

        // Directed: each strobe alone, both strobes
        host_cycle(2'b10, 1, 0, 1, 1, 1, 1, 0, 2);
        host_cycle(2'b01, 0, 1, 1, 1, 1, 0, 1, 0);   // I/O write never posted
        host_cycle(2'b00, 1, 0, 1, 1, 1, 0, 1, 1);   // memory read never posted
        host_cycle(2'b10, 1, 1, 1, 0, 1, 1, 0, 0);   // local memory
        host_cycle(2'b01, 0, 0, 1, 1, 0, 1, 0, 0);   // local I/O
        lone_done();                                  // R7
        // Posted write, then a cycle behind the drain
        host_cycle(2'b10, 1, 1, 1, 1, 1, 0, 1, 0);
        host_cycle(2'b01, 0, 0, 1, 1, 1, 1, 0, 3);
        // Posted write, local cycle during drain, then drain alone
        host_cycle(2'b10, 1, 1, 1, 1, 1, 0, 0, 0);
        host_cycle(2'b10, 1, 0, 1, 0, 1, 1, 0, 0);
        lone_done();

        // Random mix
        for (int k = 0; k < 300; k++) begin
            if ($urandom_range(0, 4) == 0) begin
                lone_done();
            end else begin
                bit [1:0] s = 2'($urandom_range(0, 2));
                host_cycle(s, 1'($urandom), 1'($urandom), 1'($urandom),
                           ($urandom_range(0, 5) != 0), ($urandom_range(0, 5) != 0),
                           1'($urandom), 1'($urandom), $urandom_range(0, 4));
            end
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
        if (busy_m) lone_done();

        // Hold relay with lock (R8, R9)
        host_lock_n = 0; arb_hold_req = 1;
        repeat (3) @(negedge clk);
        eq("R8 hold blocked by lock", host_hold, 0);
        host_lock_n = 1;
        @(negedge clk);
        eq("R8 hold after unlock", host_hold, 1);
        eq("R9 no ack before host", arb_hlda, 0);
        host_lock_n = 0;
        @(negedge clk);
        eq("R8 hold kept once given", host_hold, 1);
        host_hlda = 1;
        @(negedge clk);
        eq("R9 ack to arbiter", arb_hlda, 1);
        arb_hold_req = 0;
        @(negedge clk);
        eq("R8 hold released", host_hold, 0);
        eq("R9 ack released", arb_hlda, 0);
        host_hlda = 0; host_lock_n = 1;
        arb_hold_req = 1;
        @(negedge clk);
        eq("R8 hold unlocked immediate", host_hold, 1);
        arb_hold_req = 0;
        @(negedge clk);

        // Strap sampling (R10)
        strap_amode = 0; strap_nxt = 1; pwr_good = 1;
        repeat (6) @(negedge clk);
        eq("R10 mode on power-good rise", mode_base, 1);
        strap_amode = 1;
        repeat (4) @(negedge clk);
        eq("R10 strap change ignored", mode_base, 1);
        pwr_good = 0;
        repeat (4) @(negedge clk);
        pwr_good = 1;
        repeat (6) @(negedge clk);
        eq("R10 mode resampled", mode_base, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule